// File: doc/BRIEF.md
# Five-Level Carrier PWM Generator

This block produces the eight ideal gate commands for a single-phase inverter built from two three-level neutral-point-clamped legs. A signed modulating sample is compared against two stacked triangular carriers generated inside the block. The upper carrier covers the positive half of the modulating range and the lower carrier covers the negative half. The first leg compares the sample itself. The second leg compares the negated sample with the same rule. Each leg therefore yields an upper and a lower switch command, and every command also has a complementary output.

The carriers are one symmetric up/down counter. It rises from 0 to a programmable peak and falls back to 0, so one carrier period is twice the peak in clock cycles. The modulating value and the peak setting are captured only when the counter sits at 0, so a pulse cannot be cut short partway through a period. A signed level code, the sum of the upper-leg commands minus the sum of the lower-leg commands, reports which of the five output voltage levels is being commanded. Dead-time insertion happens downstream of this block.

Top module: `pwm5_gen`

## Requirements
- R1: For each of the four switches, gate_o[i+4] is the bitwise inverse of gate_o[i] in every cycle. Bit 0 is T1, bit 1 is T2, bit 2 is T3 and bit 3 is T4.
- R2: The internal carrier count c moves by exactly one each cycle. It runs 0,1,...,P,P-1,...,1,0 and repeats, where P is the captured peak, so one period lasts 2P cycles.
- R3: T1 (gate_o[0]) is 1 exactly when the captured signed modulating value m is strictly greater than c.
- R4: T2 (gate_o[1]) is 1 exactly when m is strictly greater than c - P.
- R5: T3 (gate_o[2]) and T4 (gate_o[3]) follow the same rules as T1 and T2, using -m in place of m.
- R6: mod_i and peak_i are captured on the clock edge at which c is 0. They take effect from the next cycle, and changes made at any other time have no effect until the next such edge.
- R7: level_o is the 3-bit two's-complement value T1 + T2 - T3 - T4, which lies in -2..+2.
- R8: A peak_i value of 0 is captured as a peak of 1.
- R9: After reset, c = 0 and the counter is rising, the held modulating value is 0 and the peak is 1. The block therefore drives gate_o = 8'h5A and level_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_i | input | DATA_W | Signed modulating sample |
| peak_i | input | CNT_W | Carrier peak count (half period in cycles) |
| gate_o | output | 8 | {T4',T3',T2',T1',T4,T3,T2,T1} ideal gate commands |
| level_o | output | 3 | Signed output level code, -2..+2 |

## Verification
A counter that skips or repeats a step shifts every later comparison, so a wrong T1..T4 bit shows up within one carrier period and then keeps recurring at the phase where the slip happened. A sample captured at the wrong point in the period makes the level code take its new value earlier or later than the bottom edge, and this is visible in the very next cycle. The sweep over every modulating value from just below -P to just above +P, across several peaks, exposes a comparison off by one (>= used instead of >) at the carrier apex or at the bottom within a single period.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
  localparam int NUM_LEGS   = 2;
  localparam int SW_PER_LEG = 2;
  localparam int NUM_SW     = NUM_LEGS * SW_PER_LEG;
endpackage

// File: rtl/pwm5_carrier.sv
module pwm5_carrier import pwm5_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] peak_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] peak_o,
  output logic             bottom_o
);
  logic [CNT_W-1:0] cnt_q, pk_q, pk_safe;
  dir_e             dir_q;

  assign bottom_o = (cnt_q == '0);
  assign pk_safe  = (peak_i == '0) ? CNT_W'(1) : peak_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pk_q  <= CNT_W'(1);
      dir_q <= DIR_UP;
    end else if (bottom_o) begin
      pk_q  <= pk_safe;
      cnt_q <= CNT_W'(1);
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= pk_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        dir_q <= DIR_DOWN;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign peak_o = pk_q;
endmodule

// File: rtl/pwm5_leg.sv
module pwm5_leg #(
  parameter int W = 10
) (
  input  logic signed [W-1:0] mod_i,
  input  logic signed [W-1:0] cnt_i,
  input  logic signed [W-1:0] peak_i,
  output logic                hi_o,
  output logic                lo_o
);
  logic signed [W-1:0] lower_carrier;
  assign lower_carrier = cnt_i - peak_i;
  assign hi_o = (mod_i > cnt_i);
  assign lo_o = (mod_i > lower_carrier);
endmodule

// File: rtl/pwm5_gen.sv
module pwm5_gen import pwm5_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] mod_i,
  input  logic [CNT_W-1:0]         peak_i,
  output logic [2*NUM_SW-1:0]      gate_o,
  output logic signed [2:0]        level_o
);
  localparam int CMP_W = ((DATA_W > CNT_W) ? DATA_W : CNT_W) + 2;

  logic [CNT_W-1:0]         cnt_w, pk_w;
  logic                     bottom_w;
  logic signed [DATA_W-1:0] mod_q;
  logic signed [CMP_W-1:0]  mod_ext, cnt_ext, pk_ext;
  logic signed [CMP_W-1:0]  leg_mod [NUM_LEGS];
  logic [NUM_SW-1:0]        sw;
  logic [2:0]               lvl_sum;

  pwm5_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .peak_i   (peak_i),
    .cnt_o    (cnt_w),
    .peak_o   (pk_w),
    .bottom_o (bottom_w)
  );

  // sample only at carrier bottom
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mod_q <= '0;
    else if (bottom_w) mod_q <= mod_i;
  end

  assign mod_ext = CMP_W'(mod_q);
  assign cnt_ext = {{(CMP_W-CNT_W){1'b0}}, cnt_w};
  assign pk_ext  = {{(CMP_W-CNT_W){1'b0}}, pk_w};

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    if (g == 0) begin : g_pos
      assign leg_mod[g] = mod_ext;
    end else begin : g_neg
      assign leg_mod[g] = -mod_ext;
    end
    pwm5_leg #(.W(CMP_W)) u_leg (
      .mod_i  (leg_mod[g]),
      .cnt_i  (cnt_ext),
      .peak_i (pk_ext),
      .hi_o   (sw[SW_PER_LEG*g]),
      .lo_o   (sw[SW_PER_LEG*g+1])
    );
  end

  always_comb lvl_sum = 3'(sw[0]) + 3'(sw[1]) - 3'(sw[2]) - 3'(sw[3]);

  assign gate_o  = {~sw, sw};
  assign level_o = signed'(lvl_sum);
endmodule

// File: rtl/pwm5_chk.sv
module pwm5_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       gate_i,
  input logic [2:0]       level_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] peak_i
);
  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_i == $past(cnt_i) + CNT_W'(1)) || (cnt_i == $past(cnt_i) - CNT_W'(1)));
  a_r2_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= peak_i);
  a_r8_peak_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_i != '0);
  a_r4_upper_implies_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i[0] |-> gate_i[1]);
  a_r5_leg_b_stacked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i[2] |-> gate_i[3]);
  a_r5_legs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_i[0] && gate_i[2]));
  a_r7_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(level_i) >= -3'sd2) && ($signed(level_i) <= 3'sd2));
endmodule

bind pwm5_gen pwm5_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .gate_i  (gate_o),
  .level_i (level_o),
  .cnt_i   (cnt_w),
  .peak_i  (pk_w)
);

// File: tb/sim_pwm5_gen.sv
module sim_pwm5_gen;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [7:0] mod_in = '0;
  logic [7:0]        peak_in = 8'd1;
  logic [7:0]        gate;
  logic signed [2:0] level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state, built from R2/R6/R8/R9
  int mc = 0, mp = 1, mm = 0;
  bit up = 1'b1;

  always #10 clk = ~clk;

  pwm5_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .mod_i(mod_in), .peak_i(peak_in),
    .gate_o(gate), .level_o(level)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc <= 0; mp <= 1; mm <= 0; up <= 1'b1;
    end else if (mc == 0) begin
      mm <= int'(mod_in);
      mp <= (peak_in == 0) ? 1 : int'(peak_in);
      mc <= 1; up <= 1'b1;
    end else if (up) begin
      if (mc >= mp) begin mc <= mc - 1; up <= 1'b0; end
      else mc <= mc + 1;
    end else mc <= mc - 1;
  end

  task automatic chk(string tag, string ctx, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", tag, ctx, $time, act, exp);
    end
  endtask

  task automatic cycle(string ctx);
    int t1, t2, t3, t4, lv;
    @(negedge clk);
    t1 = (mm > mc) ? 1 : 0;        // R3
    t2 = (mm > mc - mp) ? 1 : 0;   // R4
    t3 = (-mm > mc) ? 1 : 0;       // R5
    t4 = (-mm > mc - mp) ? 1 : 0;
    lv = t1 + t2 - t3 - t4;        // R7
    chk("R3", ctx, int'(gate[0]), t1);
    chk("R4", ctx, int'(gate[1]), t2);
    chk("R5", ctx, int'({gate[3], gate[2]}), t4 * 2 + t3);
    chk("R1", ctx, int'(gate[7:4]), int'(~gate[3:0] & 4'hF));
    chk("R7", ctx, int'(level), lv);
  endtask

  task automatic run(int pk, int m, int n, string ctx);
    @(negedge clk);
    mod_in  = 8'(m);
    peak_in = 8'(pk);
    for (int k = 0; k < n; k++) cycle(ctx);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pks [5] = '{1, 2, 3, 5, 0};
    #35;
    chk("R9", "reset gate", int'(gate), 8'h5A);
    chk("R9", "reset level", int'(level), 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9", "released gate", int'(gate), 8'h5A);

    foreach (pks[i]) begin
      int pe;
      pe = (pks[i] == 0) ? 1 : pks[i];
      for (int m = -pe - 1; m <= pe + 1; m++)
        run(pks[i], m, 4 * pe + 2, (pks[i] == 0) ? "R8 zero peak" : "R2 sweep");
    end

    // R6: inputs changed mid-period must wait for the next bottom
    run(4, 3, 2, "R6 setup");
    while (!(mc == 2 && up)) cycle("R6 wait");
    mod_in  = -8'sd4;
    peak_in = 8'd2;
    cycle("R6 held");
    chk("R6", "held level", int'(level), (3 > mc ? 1 : 0) + 1);
    for (int k = 0; k < 12; k++) cycle("R6 after");

    // extremes of the modulating range with full peak
    run(255, 127, 520, "R2 max");
    run(255, -128, 520, "R2 min");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule